// File: doc/BRIEF.md
# Processor Timer Bank with User-Counter Mode

This block holds one system timer channel and a parameterised number of per-processor timer channels. Every channel counts pulses of a shared tick input. The tick source sits outside the block. In limit mode a channel counts up to a programmed limit, wraps to zero, sets a reached flag and raises its interrupt line. The system channel always works this way. A per-processor channel can be switched into user-counter mode by its bit in a mode register on the system channel. In user-counter mode the channel becomes a 54-bit up-counter. Software reads and loads that counter as a high and a low 32-bit word, and starts and stops it through a status register. A channel in this mode never raises an interrupt.

Software reaches the block through a simple word-addressed register port: a channel select, a 3-bit word offset, and write and read strobes. Read data is registered and valid one cycle after the read strobe. The meaning of offsets 0 and 1 depends on the channel's mode. A change of a mode bit has side effects on its channel: entering user mode stops the counter, and leaving user mode restarts it.

Top module: `cpu_timer_bank`

## Requirements
- R1: After reset all mode bits are 0, no interrupt is raised, every channel runs from a count of 0 with limit 0, the status word of every processor channel reads 1, and the mode word reads 0.
- R2: In limit mode each tick advances the count field (offset 1, bits 30..9). When the next count would reach the limit (held in tick units in bits 30..9), the count returns to 0, the reached flag (offset 1, bit 31) is set and the channel interrupt rises. A limit of 0 means free-running with no reached flag and no interrupt.
- R3: In limit mode, a write to offset 0 sets the limit, clears the count and lowers the interrupt. A read of offset 0 returns the limit and clears both the reached flag and the interrupt.
- R4: The mode register is at offset 4 of the system channel (channel 0), and bit i controls processor channel i+1. A write to offset 4 through any other channel leaves the mode unchanged.
- R5: Setting a mode bit lowers that channel's interrupt, clears its running bit, and clears its count and reached flag.
- R6: In user mode, offset 0 reads {reached, count bits 62..32} and offset 1 reads count bits 31..0. Bits 8..0 of the low word are always 0, and each tick adds 1 at bit 9 with carry into the high word.
- R7: In user mode, a write to offset 0 loads count bits 62..32 from data bits 30..0, and a write to offset 1 loads count bits 31..9 from data bits 31..9. Either write clears the reached flag.
- R8: The status word (offset 3) reads the running bit on processor channels and reads 0 on the system channel. In user mode, writing data bit 0 = 1 starts the counter and writing 0 stops it. In limit mode, status writes are ignored.
- R9: A user-mode channel never raises its interrupt. At the maximum count the next tick wraps the count to 0 and sets the reached flag.
- R10: Clearing a mode bit sets that channel's running bit and restarts its count from 0 under the limit it held before.
- R11: Writing a mode bit with the value it already holds has no effect on that channel's count or running state.
- R12: In limit mode, a write to offset 2 changes the limit without clearing the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse shared by all channels |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_chan | input | CH_W | Channel select, 0 = system channel |
| bus_off | input | 3 | Word offset within the channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd |
| irq | output | NUM_CPU+1 | Interrupt per channel, bit 0 = system channel |

## Verification
The bench targets the points where the mode bit changes what an offset means. If the offset-0 read is not decoded by mode, a user-mode read would clear the reached flag or return the limit instead of the high word. If carry from the low word is lost, the high word would stay put when the low word rolls over. If the counter wraps at the wrong point, the reached flag would never set, or the interrupt would leak out, when the 54-bit maximum rolls over. Transition cases check that an interrupt pending at entry is dropped, that a stopped counter stays frozen across a same-value mode write, and that leaving user mode counts again under the old limit. Status writes in limit mode and mode writes through a processor channel are also tried, and a design that honoured either would show a stopped channel or a changed mode word.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int WORD_W    = 32;
  localparam int FRAC_W    = 9;                  // always-zero low bits of the count
  localparam int LIM_W     = WORD_W - 1 - FRAC_W; // limit-mode count field (22)
  localparam int HI_W      = WORD_W - 1;          // user high word payload (31)
  localparam int LO_TICK_W = WORD_W - FRAC_W;     // tick bits in the low word (23)
  localparam int TICK_W    = HI_W + LO_TICK_W;    // user counter width (54)
  localparam int OFF_W     = 3;

  localparam logic [OFF_W-1:0] OFF_HIGH_LIM  = 3'd0;
  localparam logic [OFF_W-1:0] OFF_LOW_CNT   = 3'd1;
  localparam logic [OFF_W-1:0] OFF_LIM_KEEP  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_STATUS    = 3'd3;
  localparam logic [OFF_W-1:0] OFF_MODE      = 3'd4;
endpackage

// File: rtl/tmr_mode_reg.sv
module tmr_mode_reg #(
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_we,
  input  logic [NUM_CPU-1:0] mode_wdata,
  output logic [NUM_CPU-1:0] mode_q,
  output logic [NUM_CPU-1:0] enter_user,
  output logic [NUM_CPU-1:0] leave_user
);
  logic [NUM_CPU-1:0] diff;

  always_comb begin
    diff       = mode_we ? (mode_wdata ^ mode_q) : '0;
    enter_user = diff & mode_wdata;
    leave_user = diff & ~mode_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= '0;
    else if (mode_we)
      mode_q <= mode_wdata;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_bank_pkg::*;
#(
  parameter bit IS_CPU = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              user,
  input  logic              enter_user,
  input  logic              leave_user,
  input  logic              wr,
  input  logic              rd,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq,
  output logic              running
);
  logic [TICK_W-1:0] ticks;
  logic [LIM_W-1:0]  limit;
  logic              reached;
  logic [LIM_W:0]    lim_next;
  logic [LIM_W-1:0]  lim_eff;
  logic              lim_wrap;
  logic              user_max;

  always_comb begin
    lim_next = {1'b0, ticks[LIM_W-1:0]} + 1'b1;
    lim_eff  = (limit == '0) ? '1 : limit;
    lim_wrap = lim_next >= {1'b0, lim_eff};
    user_max = &ticks;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ticks   <= '0;
      limit   <= '0;
      reached <= 1'b0;
      irq     <= 1'b0;
      running <= 1'b1;
    end else if (enter_user) begin
      irq     <= 1'b0;
      running <= 1'b0;
      ticks   <= '0;
      reached <= 1'b0;
    end else if (leave_user) begin
      running <= 1'b1;
      ticks   <= '0;
      reached <= 1'b0;
    end else if (wr) begin
      case (off)
        OFF_HIGH_LIM: begin
          if (user) begin
            ticks[TICK_W-1:LO_TICK_W] <= wdata[HI_W-1:0];
            reached <= 1'b0;
          end else begin
            limit <= wdata[WORD_W-2:FRAC_W];
            ticks <= '0;
            irq   <= 1'b0;
          end
        end
        OFF_LOW_CNT: begin
          if (user) begin
            ticks[LO_TICK_W-1:0] <= wdata[WORD_W-1:FRAC_W];
            reached <= 1'b0;
          end
        end
        OFF_LIM_KEEP: begin
          if (!user)
            limit <= wdata[WORD_W-2:FRAC_W];
        end
        OFF_STATUS: begin
          if (user)
            running <= wdata[0];
        end
        default: ;
      endcase
    end else begin
      if (rd && off == OFF_HIGH_LIM && !user) begin
        reached <= 1'b0;
        irq     <= 1'b0;
      end
      if (tick && running) begin
        if (user) begin
          ticks <= ticks + 1'b1;
          if (user_max)
            reached <= 1'b1;
        end else if (lim_wrap) begin
          ticks <= '0;
          if (limit != '0) begin
            reached <= 1'b1;
            irq     <= 1'b1;
          end
        end else begin
          ticks <= {{(TICK_W-LIM_W){1'b0}}, lim_next[LIM_W-1:0]};
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      OFF_HIGH_LIM:
        rdata = user ? {reached, ticks[TICK_W-1:LO_TICK_W]}
                     : {1'b0, limit, {FRAC_W{1'b0}}};
      OFF_LOW_CNT:
        rdata = user ? {ticks[LO_TICK_W-1:0], {FRAC_W{1'b0}}}
                     : {reached, ticks[LIM_W-1:0], {FRAC_W{1'b0}}};
      OFF_STATUS:
        rdata = {{(WORD_W-1){1'b0}}, IS_CPU & running};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CH_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd,
  input  logic [CH_W-1:0]               chan,
  input  logic [OFF_W-1:0]              off,
  input  logic [NUM_CPU:0][WORD_W-1:0]  ch_rdata,
  input  logic [NUM_CPU-1:0]            mode_q,
  output logic [WORD_W-1:0]             rdata
);
  localparam int NUM_CH = NUM_CPU + 1;
  logic [WORD_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (off == OFF_MODE)
      sel = {{(WORD_W-NUM_CPU){1'b0}}, mode_q};
    else
      for (int c = 0; c < NUM_CH; c++)
        if (chan == CH_W'(c))
          sel = ch_rdata[c];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= sel;
  end
endmodule

// File: rtl/cpu_timer_bank.sv
module cpu_timer_bank
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CH_W    = $clog2(NUM_CPU + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CH_W-1:0]   bus_chan,
  input  logic [2:0]        bus_off,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CPU:0]  irq
);
  localparam int NUM_CH = NUM_CPU + 1;

  logic [NUM_CPU-1:0]          mode_q;
  logic [NUM_CPU-1:0]          enter_user;
  logic [NUM_CPU-1:0]          leave_user;
  logic [NUM_CPU:0]            run;
  logic [NUM_CPU:0][WORD_W-1:0] ch_rdata;
  logic                        mode_we;

  assign mode_we = bus_wr && bus_chan == '0 && bus_off == OFF_MODE;

  tmr_mode_reg #(.NUM_CPU(NUM_CPU)) u_mode (
    .clk        (clk),
    .rst        (rst),
    .mode_we    (mode_we),
    .mode_wdata (bus_wdata[NUM_CPU-1:0]),
    .mode_q     (mode_q),
    .enter_user (enter_user),
    .leave_user (leave_user)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic ch_user, ch_enter, ch_leave;
    if (g == 0) begin : g_sys
      assign ch_user  = 1'b0;
      assign ch_enter = 1'b0;
      assign ch_leave = 1'b0;
    end else begin : g_cpu
      assign ch_user  = mode_q[g-1];
      assign ch_enter = enter_user[g-1];
      assign ch_leave = leave_user[g-1];
    end

    tmr_channel #(.IS_CPU(g != 0)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .user       (ch_user),
      .enter_user (ch_enter),
      .leave_user (ch_leave),
      .wr         (bus_wr && bus_chan == CH_W'(g)),
      .rd         (bus_rd && bus_chan == CH_W'(g)),
      .off        (bus_off),
      .wdata      (bus_wdata),
      .rdata      (ch_rdata[g]),
      .irq        (irq[g]),
      .running    (run[g])
    );
  end

  tmr_read_mux #(.NUM_CPU(NUM_CPU), .CH_W(CH_W)) u_rmux (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .chan     (bus_chan),
    .off      (bus_off),
    .ch_rdata (ch_rdata),
    .mode_q   (mode_q),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NUM_CPU = 4,
  parameter int CH_W    = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [CH_W-1:0]    bus_chan,
  input logic [2:0]         bus_off,
  input logic [NUM_CPU-1:0] mode_q,
  input logic [NUM_CPU-1:0] enter_user,
  input logic [NUM_CPU-1:0] leave_user,
  input logic [NUM_CPU:0]   run,
  input logic [NUM_CPU:0]   irq
);
  // R9: no user-mode channel ever shows an interrupt
  a_r9_user_no_irq: assert property (@(posedge clk) disable iff (rst)
    (irq[NUM_CPU:1] & mode_q) == '0);

  // R5: a channel entering user mode is stopped next cycle
  a_r5_enter_stops: assert property (@(posedge clk) disable iff (rst)
    (enter_user != '0) |=> ((run[NUM_CPU:1] & $past(enter_user)) == '0));

  // R10: a channel leaving user mode is running next cycle
  a_r10_leave_runs: assert property (@(posedge clk) disable iff (rst)
    (leave_user != '0) |=> ((run[NUM_CPU:1] & $past(leave_user)) == $past(leave_user)));

  // R4: only a system-channel write at the mode offset alters the mode
  a_r4_mode_guard: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !(bus_chan == '0 && bus_off == 3'd4)) |=> $stable(mode_q));

  // R8: channels in limit mode, and the system channel, always run
  a_r8_limit_runs: assert property (@(posedge clk) disable iff (rst)
    ((~mode_q & ~run[NUM_CPU:1]) == '0) && run[0]);
endmodule

bind cpu_timer_bank tmr_bank_chk #(.NUM_CPU(NUM_CPU), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_chan   (bus_chan),
  .bus_off    (bus_off),
  .mode_q     (mode_q),
  .enter_user (enter_user),
  .leave_user (leave_user),
  .run        (run),
  .irq        (irq)
);

// File: tb/cpu_timer_bank_test.sv
module cpu_timer_bank_test;
  localparam int NUM_CPU = 4;
  localparam int CH_W    = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [CH_W-1:0]   bus_chan = '0;
  logic [2:0]        bus_off = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NUM_CPU:0]  irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  cpu_timer_bank #(.NUM_CPU(NUM_CPU), .CH_W(CH_W)) uut (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_chan(bus_chan), .bus_off(bus_off), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_chan = CH_W'(ch); bus_off = 3'(off); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_chan = CH_W'(ch); bus_off = 3'(off);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 32'h0);
    rd(1, 3, d); chk("R1 status ch1", d, 32'h1);
    rd(0, 3, d); chk("R8 status system", d, 32'h0);
    rd(0, 4, d); chk("R1 mode", d, 32'h0);
    rd(2, 1, d); chk("R1 count", d, 32'h0);
  endtask

  task automatic t_limit;
    logic [31:0] d;
    wr(0, 0, 32'h0000_0A00);
    pulse(3);
    rd(0, 1, d); chk("R2 count", d, 32'h0000_0600);
    pulse(2);
    rd(0, 1, d); chk("R2 reached", d, 32'h8000_0000);
    chk("R2 irq", 32'(irq[0]), 32'h1);
    rd(0, 0, d); chk("R3 limit read", d, 32'h0000_0A00);
    chk("R3 irq cleared", 32'(irq[0]), 32'h0);
    rd(0, 1, d); chk("R3 reached cleared", d, 32'h0);
    wr(2, 0, 32'h0);
    pulse(10);
    rd(2, 1, d); chk("R2 free run", d, 32'h0000_1400);
    chk("R2 free run no irq", 32'(irq[2]), 32'h0);
  endtask

  task automatic t_norst;
    logic [31:0] d;
    wr(3, 0, 32'h0);
    pulse(4);
    wr(3, 2, 32'h0000_0C00);
    rd(3, 1, d); chk("R12 count kept", d, 32'h0000_0800);
    pulse(2);
    rd(3, 1, d); chk("R12 new limit", d, 32'h8000_0000);
    chk("R12 irq", 32'(irq[3]), 32'h1);
    rd(3, 0, d);
  endtask

  task automatic t_mode_guard;
    logic [31:0] d;
    wr(1, 4, 32'hF);
    rd(0, 4, d); chk("R4 write via cpu channel", d, 32'h0);
  endtask

  task automatic t_enter;
    logic [31:0] d;
    wr(1, 0, 32'h0000_0400);
    pulse(2);
    chk("R2 irq ch1", 32'(irq[1]), 32'h1);
    wr(0, 4, 32'h1);
    chk("R5 irq dropped", 32'(irq[1]), 32'h0);
    rd(0, 4, d); chk("R4 mode readback", d, 32'h1);
    rd(1, 3, d); chk("R5 stopped", d, 32'h0);
    rd(1, 0, d); chk("R5 high cleared", d, 32'h0);
    pulse(3);
    rd(1, 1, d); chk("R5 frozen", d, 32'h0);
  endtask

  task automatic t_user_count;
    logic [31:0] d;
    wr(1, 3, 32'h1);
    rd(1, 3, d); chk("R8 start", d, 32'h1);
    pulse(5);
    rd(1, 1, d); chk("R6 low", d, 32'h0000_0A00);
    rd(1, 0, d); chk("R6 high", d, 32'h0);
  endtask

  task automatic t_user_load;
    logic [31:0] d;
    wr(1, 0, 32'h1234_5678);
    wr(1, 1, 32'hABCD_E3FF);
    rd(1, 0, d); chk("R7 high load", d, 32'h1234_5678);
    rd(1, 1, d); chk("R7 low load", d, 32'hABCD_E200);
    pulse(1);
    rd(1, 1, d); chk("R6 bit9 step", d, 32'hABCD_E400);
    wr(1, 1, 32'hFFFF_FE00);
    pulse(1);
    rd(1, 1, d); chk("R6 low wrap", d, 32'h0);
    rd(1, 0, d); chk("R6 carry", d, 32'h1234_5679);
  endtask

  task automatic t_user_max;
    logic [31:0] d;
    wr(1, 0, 32'h7FFF_FFFF);
    wr(1, 1, 32'hFFFF_FE00);
    pulse(1);
    rd(1, 0, d); chk("R9 reached at max", d, 32'h8000_0000);
    rd(1, 1, d); chk("R9 wrap low", d, 32'h0);
    chk("R9 no irq", 32'(irq[1]), 32'h0);
    wr(1, 1, 32'h0);
    rd(1, 0, d); chk("R7 reached cleared", d, 32'h0);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(1, 3, 32'h0);
    rd(1, 3, d); chk("R8 stop", d, 32'h0);
    pulse(4);
    rd(1, 1, d); chk("R8 stopped count", d, 32'h0);
    wr(1, 3, 32'h1);
    pulse(2);
    wr(1, 3, 32'h0);
    pulse(3);
    rd(1, 1, d); chk("R8 stop holds", d, 32'h0000_0400);
  endtask

  task automatic t_same_mode;
    logic [31:0] d;
    wr(0, 4, 32'h1);
    rd(1, 3, d); chk("R11 still stopped", d, 32'h0);
    rd(1, 1, d); chk("R11 count kept", d, 32'h0000_0400);
    wr(1, 3, 32'h1);
    pulse(1);
    wr(0, 4, 32'h1);
    rd(1, 3, d); chk("R11 still running", d, 32'h1);
    rd(1, 1, d); chk("R11 count kept run", d, 32'h0000_0600);
  endtask

  task automatic t_limit_status;
    logic [31:0] d;
    wr(2, 0, 32'h0);
    wr(2, 3, 32'h0);
    rd(2, 3, d); chk("R8 limit status ignored", d, 32'h1);
    pulse(2);
    rd(2, 1, d); chk("R8 limit keeps counting", d, 32'h0000_0400);
  endtask

  task automatic t_leave;
    logic [31:0] d;
    wr(0, 4, 32'h0);
    rd(1, 3, d); chk("R10 running", d, 32'h1);
    rd(1, 1, d); chk("R10 restart", d, 32'h0);
    pulse(3);
    rd(1, 1, d); chk("R10 old limit", d, 32'h8000_0200);
    chk("R10 irq", 32'(irq[1]), 32'h1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_limit();
    t_norst();
    t_mode_guard();
    t_enter();
    t_user_count();
    t_user_load();
    t_user_max();
    t_stop();
    t_same_mode();
    t_limit_status();
    t_leave();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule